// File: doc/BRIEF.md
# Task-File Data Port Byte Steering

This block is the host-facing access logic for the data port of an ATA-style task file. A host bus carrying 16 data bits, two active-low lane enables, a memory/I/O space flag and read/write strobes is decoded against one of four window configurations. The block then steers each hit to one of two places. A whole word or a single byte goes to the internal 16-bit data FIFO. A byte goes to the error register (on reads) or the feature register (on writes).

Three data offsets alias the same FIFO. Byte accesses and word accesses can be mixed. A byte-phase pointer records which half of the current FIFO word has already been moved. A FIFO word is popped or pushed only when both of its bytes have been transferred, or when a word access moves it whole. If a read finds the FIFO empty, the block returns zero and latches a sticky underflow flag. If the host repeats an odd-byte access at the odd-only offset, the block latches a sticky protocol-error flag and does not advance.

Top module: `ata_byte_steer`

## Requirements
- R1: After synchronous reset, `feature` is 00h, `underflow` and `proto_err` are 0, and the byte-phase pointer holds no byte, so the first byte access at offset 0 moves the even byte.
- R2: A word access is `host_ce_n`=2'b00 at offset 0, 8 or 9. It moves one whole FIFO word in the same cycle. On a read, `host_rdata` equals the FIFO head and `rd_fifo_pop` pulses. On a write, `wr_fifo_push` pulses with `wr_fifo_data`=`host_wdata`.
- R3: An even-lane byte access is `host_ce_n`=2'b10, and its data sits on bits 7:0. Repeated even-lane byte accesses at offset 0 or 8 move the even byte (bits 7:0 of the word) and then the odd byte (bits 15:8). The FIFO pops or pushes only on the second access, and a written word is {odd byte, even byte}.
- R4: An even-lane byte access at offset 9 followed by one at offset 8 moves the odd byte first and the even byte second, both from the same FIFO word. The FIFO moves on the second access.
- R5: Alternating even-lane byte accesses at offset 8 then offset 9 move the even byte and then the odd byte of one word. The FIFO moves on the offset-9 access.
- R6: An even-lane byte access at offset 9 while the odd byte of the current word is already held is a protocol error. It sets a sticky `proto_err`, does not pop or push, ignores the written byte and leaves the pointer unchanged. A read returns the odd byte again.
- R7: An odd-lane byte access (`host_ce_n`=2'b01) at offset 0, 1, 8 or D, or an even-lane byte access at offset 1 or D, reaches the error/feature register and never the FIFO. A read returns `err_code` on the selected lane with the other lane 0. A write loads `feature` from the selected lane on the next edge.
- R8: A word access returns the byte-phase pointer to empty, so the next even-lane byte access at offset 0 moves the even byte of the next word.
- R9: A data read that finds `rd_fifo_empty` high returns 0000h, does not pop, and sets `underflow`. The flag stays set until reset, and the byte pointer still advances.
- R10: `cfg_idx` selects the decode window. Value 0 is memory space: offsets 0h–Fh at addresses 000h–00Fh, with addresses 400h–7FFh acting as data offset 0. Value 1 is I/O space with address bits 10:4 equal to `io_base`, and the offset is taken from address bits 3:0. Value 2 is I/O 1F0h–1F7h (offsets 0–7) plus 3F6h–3F7h (offsets E–F). Value 3 is I/O 170h–177h plus 376h–377h. A miss drops `host_hit` and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_idx | input | 2 | Decode window selection (0 memory, 1 relocatable I/O, 2 primary I/O, 3 secondary I/O) |
| io_base | input | 7 | Address bits 10:4 of the relocatable I/O block |
| host_mem | input | 1 | 1 = memory-space cycle, 0 = I/O-space cycle |
| host_addr | input | 11 | Host byte address |
| host_ce_n | input | 2 | Active-low lane enables: bit 0 even lane (7:0), bit 1 odd lane (15:8) |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wr | input | 1 | Write strobe, one cycle per access (ignored if host_rd is also high) |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid in the strobe cycle |
| host_hit | output | 1 | Address lies in the selected window |
| rd_fifo_data | input | 16 | Head word of the read FIFO |
| rd_fifo_empty | input | 1 | Read FIFO holds no word |
| rd_fifo_pop | output | 1 | Remove the head word of the read FIFO |
| wr_fifo_push | output | 1 | Append wr_fifo_data to the write FIFO |
| wr_fifo_data | output | 16 | Word to append |
| err_code | input | 8 | Current contents of the error register |
| feature | output | 8 | Feature register |
| underflow | output | 1 | Sticky: a data read found the FIFO empty |
| proto_err | output | 1 | Sticky: repeated odd-only byte access |

## Verification
The hardest state to reach is the one where the pointer already holds the odd byte of a word. Only an offset-9 byte access taken from the empty phase leads there. The repeated-odd error and the odd-first completion both depend on it, so the stimulus drives 9→8 and 9→9→8 sequences on both the read path and the write path. It also checks that the held odd byte survives a rejected write. Underflow needs the FIFO drained. The bench owns the FIFO contents as a queue and keeps reading after the last word, with both word accesses and byte accesses.

// File: rtl/ata_steer_pkg.sv
package ata_steer_pkg;

    typedef enum logic [1:0] {
        CFG_MEM    = 2'd0,
        CFG_IO_ANY = 2'd1,
        CFG_IO_PRI = 2'd2,
        CFG_IO_SEC = 2'd3
    } cfg_e;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_WORD,
        ACC_SEQ_BYTE,
        ACC_ODD_BYTE,
        ACC_ERRFEAT
    } acc_kind_e;

    typedef enum logic [1:0] {
        PH_EMPTY,
        PH_HAVE_EVEN,
        PH_HAVE_ODD
    } phase_e;

    typedef struct packed {
        logic       hit;
        logic [3:0] off;
    } win_t;

    typedef struct packed {
        acc_kind_e kind;
        logic      hi_lane;
    } acc_t;

    localparam logic [3:0] OFF_DATA     = 4'h0;
    localparam logic [3:0] OFF_ERRF     = 4'h1;
    localparam logic [3:0] OFF_DATA_ALT = 4'h8;
    localparam logic [3:0] OFF_ODD      = 4'h9;
    localparam logic [3:0] OFF_ERRF_ALT = 4'hD;

    localparam logic [1:0] LANES_BOTH = 2'b00;
    localparam logic [1:0] LANE_EVEN  = 2'b10;
    localparam logic [1:0] LANE_ODD   = 2'b01;

    function automatic acc_t classify(input logic [3:0] off, input logic [1:0] ce_n);
        acc_t a;
        a.kind    = ACC_NONE;
        a.hi_lane = 1'b0;
        unique case (ce_n)
            LANES_BOTH: begin
                if (off == OFF_DATA || off == OFF_DATA_ALT || off == OFF_ODD)
                    a.kind = ACC_WORD;
            end
            LANE_EVEN: begin
                if (off == OFF_DATA || off == OFF_DATA_ALT)
                    a.kind = ACC_SEQ_BYTE;
                else if (off == OFF_ODD)
                    a.kind = ACC_ODD_BYTE;
                else if (off == OFF_ERRF || off == OFF_ERRF_ALT)
                    a.kind = ACC_ERRFEAT;
            end
            LANE_ODD: begin
                if (off == OFF_DATA || off == OFF_DATA_ALT ||
                    off == OFF_ERRF || off == OFF_ERRF_ALT) begin
                    a.kind    = ACC_ERRFEAT;
                    a.hi_lane = 1'b1;
                end
            end
            default: a.kind = ACC_NONE;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/ata_win_decode.sv
module ata_win_decode
    import ata_steer_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter logic [ADDR_W-1:0] PRI_CMD_BASE = ADDR_W'(12'h1F0),
    parameter logic [ADDR_W-1:0] PRI_CTL_BASE = ADDR_W'(12'h3F6),
    parameter logic [ADDR_W-1:0] SEC_CMD_BASE = ADDR_W'(12'h170),
    parameter logic [ADDR_W-1:0] SEC_CTL_BASE = ADDR_W'(12'h376),
    parameter logic [ADDR_W-1:0] MEM_DATA_LO  = ADDR_W'(12'h400),
    parameter logic [ADDR_W-1:0] MEM_DATA_HI  = ADDR_W'(12'h7FF)
) (
    input  logic [1:0]        cfg_idx,
    input  logic [ADDR_W-5:0] io_base,
    input  logic              mem_space,
    input  logic [ADDR_W-1:0] addr,
    output win_t              win
);
    logic in_pri_cmd, in_pri_ctl, in_sec_cmd, in_sec_ctl;

    always_comb begin
        in_pri_cmd = addr[ADDR_W-1:3] == PRI_CMD_BASE[ADDR_W-1:3];
        in_pri_ctl = addr[ADDR_W-1:1] == PRI_CTL_BASE[ADDR_W-1:1];
        in_sec_cmd = addr[ADDR_W-1:3] == SEC_CMD_BASE[ADDR_W-1:3];
        in_sec_ctl = addr[ADDR_W-1:1] == SEC_CTL_BASE[ADDR_W-1:1];
        win = '0;
        unique case (cfg_e'(cfg_idx))
            CFG_MEM: begin
                if (mem_space && addr >= MEM_DATA_LO && addr <= MEM_DATA_HI) begin
                    win.hit = 1'b1;
                    win.off = OFF_DATA;
                end else if (mem_space && addr[ADDR_W-1:4] == '0) begin
                    win.hit = 1'b1;
                    win.off = addr[3:0];
                end
            end
            CFG_IO_ANY: begin
                if (!mem_space && addr[ADDR_W-1:4] == io_base) begin
                    win.hit = 1'b1;
                    win.off = addr[3:0];
                end
            end
            CFG_IO_PRI, CFG_IO_SEC: begin
                if (!mem_space &&
                    (cfg_idx == CFG_IO_PRI ? in_pri_cmd : in_sec_cmd)) begin
                    win.hit = 1'b1;
                    win.off = {1'b0, addr[2:0]};
                end else if (!mem_space &&
                    (cfg_idx == CFG_IO_PRI ? in_pri_ctl : in_sec_ctl)) begin
                    win.hit = 1'b1;
                    win.off = {3'b111, addr[0]};
                end
            end
            default: win = '0;
        endcase
    end
endmodule

// File: rtl/ata_phase_ctl.sv
module ata_phase_ctl
    import ata_steer_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      act,
    input  acc_kind_e kind,
    output phase_e    phase,
    output logic      complete,
    output logic      odd_now,
    output logic      bad,
    output logic      proto_err
);
    phase_e phase_q, phase_d;
    logic   proto_q;

    always_comb begin
        phase_d  = phase_q;
        complete = 1'b0;
        odd_now  = 1'b0;
        bad      = 1'b0;
        if (act) begin
            unique case (kind)
                ACC_WORD: begin
                    complete = 1'b1;
                    phase_d  = PH_EMPTY;
                end
                ACC_SEQ_BYTE: begin
                    unique case (phase_q)
                        PH_HAVE_EVEN: begin
                            odd_now  = 1'b1;
                            complete = 1'b1;
                            phase_d  = PH_EMPTY;
                        end
                        PH_HAVE_ODD: begin
                            complete = 1'b1;
                            phase_d  = PH_EMPTY;
                        end
                        default: phase_d = PH_HAVE_EVEN;
                    endcase
                end
                ACC_ODD_BYTE: begin
                    odd_now = 1'b1;
                    unique case (phase_q)
                        PH_HAVE_EVEN: begin
                            complete = 1'b1;
                            phase_d  = PH_EMPTY;
                        end
                        PH_HAVE_ODD: bad = 1'b1;
                        default: phase_d = PH_HAVE_ODD;
                    endcase
                end
                default: phase_d = phase_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_EMPTY;
            proto_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (bad) proto_q <= 1'b1;
        end
    end

    assign phase     = phase_q;
    assign proto_err = proto_q;
endmodule

// File: rtl/ata_data_path.sv
module ata_data_path
    import ata_steer_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act,
    input  logic              is_wr,
    input  acc_t              acc,
    input  logic              complete,
    input  logic              odd_now,
    input  logic              bad,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] fifo_rdata,
    input  logic              fifo_empty,
    input  logic [BYTE_W-1:0] err_code,
    output logic [WORD_W-1:0] rdata,
    output logic              pop,
    output logic              push,
    output logic [WORD_W-1:0] push_data,
    output logic [BYTE_W-1:0] feature,
    output logic              underflow
);
    localparam int LANES = WORD_W / BYTE_W;

    logic              is_data, is_byte, data_rd, data_wr;
    logic [BYTE_W-1:0] wr_byte, rd_byte, hold_lo, hold_hi, feat_q;
    logic              unf_q;

    always_comb begin
        is_data = acc.kind inside {ACC_WORD, ACC_SEQ_BYTE, ACC_ODD_BYTE};
        is_byte = acc.kind != ACC_WORD;
        data_rd = act && !is_wr && is_data;
        data_wr = act && is_wr && is_data;
        wr_byte = wdata[BYTE_W-1:0];
        rd_byte = odd_now ? fifo_rdata[WORD_W-1:BYTE_W] : fifo_rdata[BYTE_W-1:0];
        pop     = data_rd && complete && !fifo_empty;
        push    = data_wr && complete;
        if (!is_byte)     push_data = wdata;
        else if (odd_now) push_data = {wr_byte, hold_lo};
        else              push_data = {hold_hi, wr_byte};
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane;
        always_comb begin
            lane = '0;
            if (act && !is_wr) begin
                if (acc.kind == ACC_ERRFEAT) begin
                    if (acc.hi_lane == 1'(g)) lane = err_code;
                end else if (is_data && !fifo_empty) begin
                    if (!is_byte)    lane = fifo_rdata[g*BYTE_W +: BYTE_W];
                    else if (g == 0) lane = rd_byte;
                end
            end
        end
        assign rdata[g*BYTE_W +: BYTE_W] = lane;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_lo <= '0;
            hold_hi <= '0;
            feat_q  <= '0;
            unf_q   <= 1'b0;
        end else begin
            if (data_wr && is_byte && !bad) begin
                if (odd_now) hold_hi <= wr_byte;
                else         hold_lo <= wr_byte;
            end
            if (act && is_wr && acc.kind == ACC_ERRFEAT)
                feat_q <= acc.hi_lane ? wdata[WORD_W-1:BYTE_W] : wdata[BYTE_W-1:0];
            if (data_rd && fifo_empty) unf_q <= 1'b1;
        end
    end

    assign feature   = feat_q;
    assign underflow = unf_q;
endmodule

// File: rtl/ata_byte_steer.sv
module ata_byte_steer
    import ata_steer_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int BYTE_W = 8,
    parameter int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_idx,
    input  logic [ADDR_W-5:0] io_base,
    input  logic              host_mem,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [1:0]        host_ce_n,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic              host_hit,
    input  logic [WORD_W-1:0] rd_fifo_data,
    input  logic              rd_fifo_empty,
    output logic              rd_fifo_pop,
    output logic              wr_fifo_push,
    output logic [WORD_W-1:0] wr_fifo_data,
    input  logic [BYTE_W-1:0] err_code,
    output logic [BYTE_W-1:0] feature,
    output logic              underflow,
    output logic              proto_err
);
    win_t   win;
    acc_t   acc;
    phase_e phase;
    logic   act, is_wr, complete, odd_now, bad;

    ata_win_decode #(.ADDR_W(ADDR_W)) u_dec (
        .cfg_idx  (cfg_idx),
        .io_base  (io_base),
        .mem_space(host_mem),
        .addr     (host_addr),
        .win      (win)
    );

    always_comb begin
        acc      = classify(win.off, host_ce_n);
        act      = win.hit && (host_rd || host_wr);
        is_wr    = host_wr && !host_rd;
        host_hit = win.hit;
    end

    ata_phase_ctl u_phase (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .kind     (acc.kind),
        .phase    (phase),
        .complete (complete),
        .odd_now  (odd_now),
        .bad      (bad),
        .proto_err(proto_err)
    );

    ata_data_path #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .is_wr     (is_wr),
        .acc       (acc),
        .complete  (complete),
        .odd_now   (odd_now),
        .bad       (bad),
        .wdata     (host_wdata),
        .fifo_rdata(rd_fifo_data),
        .fifo_empty(rd_fifo_empty),
        .err_code  (err_code),
        .rdata     (host_rdata),
        .pop       (rd_fifo_pop),
        .push      (wr_fifo_push),
        .push_data (wr_fifo_data),
        .feature   (feature),
        .underflow (underflow)
    );
endmodule

// File: rtl/ata_byte_steer_chk.sv
module ata_byte_steer_chk
    import ata_steer_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              host_rd,
    input logic              host_wr,
    input logic              host_hit,
    input logic              rd_fifo_pop,
    input logic              rd_fifo_empty,
    input logic              wr_fifo_push,
    input logic [BYTE_W-1:0] feature,
    input logic              underflow,
    input logic              proto_err,
    input phase_e            phase
);
    p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (rst)
        rd_fifo_pop |-> !rd_fifo_empty);

    p_underflow_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        underflow |=> underflow);

    p_proto_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

    p_one_move_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_fifo_pop, wr_fifo_push}));

    p_pop_needs_read_r2: assert property (@(posedge clk) disable iff (rst)
        rd_fifo_pop |-> host_rd);

    p_feature_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !host_wr |=> $stable(feature));

    p_miss_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !host_hit |-> (!rd_fifo_pop && !wr_fifo_push));

    p_move_clears_phase_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_fifo_pop || wr_fifo_push) |=> phase == PH_EMPTY);
endmodule

bind ata_byte_steer ata_byte_steer_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .host_rd      (host_rd),
    .host_wr      (host_wr),
    .host_hit     (host_hit),
    .rd_fifo_pop  (rd_fifo_pop),
    .rd_fifo_empty(rd_fifo_empty),
    .wr_fifo_push (wr_fifo_push),
    .feature      (feature),
    .underflow    (underflow),
    .proto_err    (proto_err),
    .phase        (phase)
);

// File: tb/ata_byte_steer_test.sv
`timescale 1ns/1ps
module ata_byte_steer_test;
    localparam int ERRV = 8'h5A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_idx = 2'd0;
    logic [6:0]  io_base = 7'h25;
    logic        host_mem = 1'b1;
    logic [10:0] host_addr = '0;
    logic [1:0]  host_ce_n = 2'b11;
    logic        host_rd = 1'b0, host_wr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_hit;
    logic [15:0] rd_fifo_data = '0;
    logic        rd_fifo_empty = 1'b1;
    logic        rd_fifo_pop, wr_fifo_push;
    logic [15:0] wr_fifo_data;
    logic [7:0]  err_code = ERRV[7:0];
    logic [7:0]  feature;
    logic        underflow, proto_err;

    ata_byte_steer uut (.*);

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    int rxq[$];

    // reference state
    int m_ph = 0, m_lo = 0, m_hi = 0, m_feat = 0, m_unf = 0, m_prot = 0;
    int n_ph, n_lo, n_hi, n_feat, n_unf, n_prot;
    int e_hit, e_rdata, e_pop, e_push, e_pdata;

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int decode_off(bit mem, int a);
        case (cfg_idx)
            2'd0: begin
                if (mem && a >= 1024 && a < 2048) return 0;
                if (mem && a < 16) return a;
            end
            2'd1: if (!mem && (a / 16) == int'(io_base)) return a % 16;
            2'd2: begin
                if (!mem && a >= 496 && a <= 503) return a - 496;
                if (!mem && (a == 1014 || a == 1015)) return a - 1000;
            end
            default: begin
                if (!mem && a >= 368 && a <= 375) return a - 368;
                if (!mem && (a == 886 || a == 887)) return a - 872;
            end
        endcase
        return -1;
    endfunction

    // 0 none, 1 word, 2 even-lane data byte at 0/8, 3 odd-only byte, 4 err lo lane, 5 err hi lane
    function automatic int kind_of(int off, bit [1:0] ce);
        if (ce == 2'b00 && (off == 0 || off == 8 || off == 9)) return 1;
        if (ce == 2'b10) begin
            if (off == 0 || off == 8) return 2;
            if (off == 9) return 3;
            if (off == 1 || off == 13) return 4;
        end
        if (ce == 2'b01 && (off == 0 || off == 1 || off == 8 || off == 13)) return 5;
        return 0;
    endfunction

    task automatic model(bit mem, int addr, bit [1:0] ce, bit rd, bit wr, int wd);
        int off, k, b;
        bit w, odd, fin, bad;
        off = decode_off(mem, addr);
        k = (off >= 0) ? kind_of(off, ce) : 0;
        w = wr && !rd;
        b = wd & 255;
        e_hit = (off >= 0); e_rdata = 0; e_pop = 0; e_push = 0; e_pdata = 0;
        n_ph = m_ph; n_lo = m_lo; n_hi = m_hi; n_feat = m_feat; n_unf = m_unf; n_prot = m_prot;
        if (off >= 0 && (rd || wr)) begin
            case (k)
                1: begin
                    n_ph = 0;
                    if (w) begin e_push = 1; e_pdata = wd & 16'hFFFF; end
                    else if (rxq.size() > 0) begin e_rdata = rxq[0]; e_pop = 1; end
                    else n_unf = 1;
                end
                2, 3: begin
                    bad = 0;
                    if (k == 2) begin
                        odd = (m_ph == 1); fin = (m_ph != 0); n_ph = fin ? 0 : 1;
                    end else if (m_ph == 2) begin
                        bad = 1; odd = 1; fin = 0; n_prot = 1;
                    end else begin
                        odd = 1; fin = (m_ph == 1); n_ph = fin ? 0 : 2;
                    end
                    if (w) begin
                        if (!bad) begin if (odd) n_hi = b; else n_lo = b; end
                        if (fin) begin
                            e_push = 1;
                            e_pdata = odd ? (b * 256 + m_lo) : (m_hi * 256 + b);
                        end
                    end else begin
                        if (rxq.size() > 0) begin
                            e_rdata = odd ? (rxq[0] >> 8) : (rxq[0] & 255);
                            if (fin) e_pop = 1;
                        end else n_unf = 1;
                    end
                end
                4: if (w) n_feat = b; else e_rdata = ERRV;
                5: if (w) n_feat = (wd >> 8) & 255; else e_rdata = ERRV * 256;
                default: ;
            endcase
        end
    endtask

    task automatic feed();
        rd_fifo_empty = (rxq.size() == 0);
        rd_fifo_data  = (rxq.size() == 0) ? 16'h0 : 16'(rxq[0]);
    endtask

    task automatic step(string tag, bit mem, int addr, bit [1:0] ce, bit rd, bit wr, int wd);
        @(negedge clk);
        host_mem = mem; host_addr = addr[10:0]; host_ce_n = ce;
        host_rd = rd; host_wr = wr; host_wdata = wd[15:0];
        feed();
        #5;
        model(mem, addr, ce, rd, wr, wd);
        chk(tag, "hit", int'(host_hit), e_hit);
        if (rd) chk(tag, "rdata", int'(host_rdata), e_rdata);
        chk(tag, "pop", int'(rd_fifo_pop), e_pop);
        chk(tag, "push", int'(wr_fifo_push), e_push);
        if (e_push) chk(tag, "push_data", int'(wr_fifo_data), e_pdata);
        chk(tag, "feature", int'(feature), m_feat);
        chk(tag, "underflow", int'(underflow), m_unf);
        chk(tag, "proto_err", int'(proto_err), m_prot);
        @(posedge clk);
        m_ph = n_ph; m_lo = n_lo; m_hi = n_hi; m_feat = n_feat;
        m_unf = n_unf; m_prot = n_prot;
        if (e_pop) void'(rxq.pop_front());
    endtask

    task automatic rdw(string t, int a, int ofs = 0);  step(t, 1, a + ofs, 2'b00, 1, 0, 0); endtask
    task automatic rdb(string t, int a);               step(t, 1, a, 2'b10, 1, 0, 0); endtask
    task automatic wrb(string t, int a, int d);        step(t, 1, a, 2'b10, 0, 1, d); endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1: reset state, then first byte at offset 0 is the even byte
        step("R1", 1, 0, 2'b11, 0, 0, 0);
        chk("R1", "feature_rst", int'(feature), 0);
        chk("R1", "underflow_rst", int'(underflow), 0);
        chk("R1", "proto_rst", int'(proto_err), 0);
        rxq = '{16'hA1B2, 16'hC3D4, 16'hE5F6, 16'h0718, 16'h293A,
                16'h4B5C, 16'h6D7E, 16'h8F90, 16'h1357, 16'h2468};
        // R2: word reads at the three aliased offsets
        rdw("R2", 0); rdw("R2", 8); rdw("R2", 9);
        // R3: repeated byte reads at 0
        rdb("R1", 0); rdb("R3", 0);
        // R5: 8 then 9
        rdb("R5", 8); rdb("R5", 9);
        // R4: 9 then 8
        rdb("R4", 9); rdb("R4", 8);
        // R6: repeated 9 flagged, no advance
        rdb("R6", 9); rdb("R6", 9); rdb("R6", 8);
        // R8: word access resets the pointer
        rdb("R8", 0); rdw("R8", 0); rdb("R8", 0); rdb("R8", 0);
        // R7: error / feature paths
        step("R7", 1, 0,  2'b01, 1, 0, 0);
        step("R7", 1, 1,  2'b10, 1, 0, 0);
        step("R7", 1, 1,  2'b10, 0, 1, 16'h00C6);
        step("R7", 1, 13, 2'b01, 0, 1, 16'h3300);
        step("R7", 1, 8,  2'b01, 0, 1, 16'h9900);
        step("R7", 1, 13, 2'b10, 1, 0, 0);
        // R9: drain and underflow
        rdw("R9", 0); rdw("R9", 0); rdb("R9", 0); rdb("R9", 8);
        // write side
        step("R2", 1, 0, 2'b00, 0, 1, 16'hBEEF);
        wrb("R3", 8, 16'h0011); wrb("R3", 8, 16'h0022);
        wrb("R4", 9, 16'h0033); wrb("R4", 8, 16'h0044);
        wrb("R5", 8, 16'h0055); wrb("R5", 9, 16'h0066);
        wrb("R6", 9, 16'h0077); wrb("R6", 9, 16'h0088); wrb("R6", 8, 16'h0099);
        wrb("R8", 0, 16'h00AB); step("R8", 1, 9, 2'b00, 0, 1, 16'h1234);
        wrb("R8", 0, 16'h00CD); wrb("R8", 0, 16'h00EF);
        // R10: window decode
        step("R10", 1, 11'h400, 2'b00, 0, 1, 16'h1111);
        step("R10", 1, 11'h7FE, 2'b00, 0, 1, 16'h2222);
        step("R10", 1, 11'h010, 2'b00, 0, 1, 16'h3333);
        step("R10", 0, 11'h000, 2'b00, 0, 1, 16'h4444);
        cfg_idx = 2'd1;
        step("R10", 0, 11'h258, 2'b00, 0, 1, 16'h5555);
        step("R10", 0, 11'h268, 2'b00, 0, 1, 16'h6666);
        step("R10", 1, 11'h250, 2'b00, 0, 1, 16'h6767);
        cfg_idx = 2'd2;
        step("R10", 0, 11'h1F0, 2'b00, 0, 1, 16'h7777);
        step("R10", 0, 11'h1F1, 2'b10, 0, 1, 16'h0042);
        step("R10", 0, 11'h3F6, 2'b00, 1, 0, 0);
        step("R10", 0, 11'h1F8, 2'b00, 0, 1, 16'h8888);
        step("R10", 0, 11'h170, 2'b00, 0, 1, 16'h9999);
        cfg_idx = 2'd3;
        step("R10", 0, 11'h170, 2'b00, 0, 1, 16'hAAAA);
        step("R10", 0, 11'h377, 2'b10, 1, 0, 0);
        step("R10", 0, 11'h171, 2'b01, 1, 0, 0);
        step("R10", 0, 11'h1F0, 2'b00, 0, 1, 16'hBBBB);
        @(negedge clk);
        host_rd = 1'b0; host_wr = 1'b0;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule